// File: doc/BRIEF.md
# Binary-Field Inverter (almost-inverse method)

This block finds the multiplicative inverse of a non-zero element A(x) of GF(2^m). The element is kept in polynomial basis, and the inverse is taken modulo an irreducible polynomial P(x) of degree m. The field is chosen at run time: the degree m and the polynomial P are driven on the ports together with the operand, and m may be anything up to the `W` parameter. The datapath needs only bitwise XOR, one-bit right shifts and small integer subtractions on degree values. It uses no multiplier.

Four polynomial registers, the working values Y and D and the cofactors X and B, advance by one step on every busy cycle. A step is one of two kinds. If Y is even, Y is divided by x, and X is multiplied by x⁻¹ modulo P: P is XORed in first when X is odd, and the result is then shifted right. If Y is odd and not yet 1, Y absorbs D and X absorbs B. When Y has the lower degree, D and B then absorb the new Y and X. This exchanges the roles of the two pairs without a register swap. The whole invariant is X·A ≡ Y and B·A ≡ D (mod P), so X is the inverse when Y reaches 1. A zero operand is flagged at once.

A typical caller loads m, A and P and pulses `start`. It then waits for the `done` pulse and reads `x_out`, which stays valid until the next operation completes.

Top module: `gf2m_inverter`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `x_out` is 0.
- R2: For an irreducible P of degree m (2 ≤ m ≤ W) and a non-zero A, the `done` pulse presents an `x_out` with (x_out·A) mod P = 1. Every bit of `x_out` at position m or above is 0.
- R3: A start whose operand is zero after masking to m bits completes on the same clock edge that accepts it. On the next cycle `done` and `err` are both 1 and `x_out` is 0, and `busy` never rises.
- R4: Bits of `a_in` at position m and above, and bits of `p_in` above position m, have no effect on the result.
- R5: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with the result for its own operand.
- R6: `done` is never high together with `busy`. Without a new start it lasts one cycle.
- R7: For A = 1 the operation takes exactly one busy cycle and returns `x_out` = 1.
- R8: A non-zero operation keeps `busy` high for at most 4·W+4 cycles.
- R9: `x_out` changes only on a cycle where `done` is 1. Otherwise it holds the last result.
- R10: `err` is 1 only together with `done`, and only for a zero operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion when idle |
| m_in | input | $clog2(W+1) | Field degree m |
| a_in | input | W | Operand A(x); bit i is the coefficient of x^i |
| p_in | input | W+1 | Reduction polynomial P(x); bit m must be 1 |
| busy | output | 1 | An inversion is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero operand, valid with `done` |
| x_out | output | W | Inverse of A, held until the next completion |

## Verification
The hardest situation to reach is a long chain of alternating exchange and shift steps that pushes the latency toward its bound. It only appears for operands with particular degree patterns relative to P. The stimulus gets there in two ways. It sweeps every non-zero element of a degree-4 field. It also draws a few hundred random operands over irreducible polynomials for every degree from 8 to 16, so many degree relationships between Y and D occur. Directed cases add a start pulse injected mid-run, operands with garbage in their upper bits, the unit element and the zero operand.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} inv_state_t;
endpackage

// File: rtl/gfinv_msb_enc.sv
module gfinv_msb_enc #(
  parameter int WIDTH = 17,
  parameter int DW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [DW-1:0]    deg
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    deg = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) deg = DW'(i);
    end
  end
endmodule

// File: rtl/gfinv_step.sv
module gfinv_step #(
  parameter int W  = 16,
  parameter int DW = $clog2(W+1)
) (
  input  logic [W:0]    y,
  input  logic [W:0]    d,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  b,
  input  logic [W:0]    p,
  input  logic [DW-1:0] deg_y,
  input  logic [DW-1:0] deg_d,
  output logic [W:0]    y_nx,
  output logic [W:0]    d_nx,
  output logic [W-1:0]  x_nx,
  output logic [W-1:0]  b_nx,
  output logic          shift_ev,
  output logic          unit_ev,
  output logic          swap_ev
);
  // x^-1 times v modulo poly: fold poly in when v is odd, then drop bit 0
  function automatic logic [W-1:0] div_by_x(logic [W-1:0] v, logic [W:0] poly);
    logic [W:0] t;
    t = {1'b0, v} ^ (v[0] ? poly : '0);
    return t[W:1];
  endfunction

  // v <= 1 tested as "1 - v is not negative"
  function automatic logic at_most_one(logic [W:0] v);
    logic [W+1:0] diff;
    diff = (W+2)'(1) - {1'b0, v};
    return ~diff[W+1];
  endfunction

  // degree ordering through an integer difference and its sign
  function automatic logic deg_below(logic [DW-1:0] da, logic [DW-1:0] db);
    logic [DW:0] diff;
    diff = {1'b0, da} - {1'b0, db};
    return diff[DW];
  endfunction

  logic [W:0]   y_sum;
  logic [W-1:0] x_sum;

  assign shift_ev = ~y[0];
  assign unit_ev  = y[0] & at_most_one(y);
  assign swap_ev  = y[0] & ~unit_ev & deg_below(deg_y, deg_d);
  assign y_sum    = y ^ d;
  assign x_sum    = x ^ b;

  always_comb begin
    y_nx = y;
    d_nx = d;
    x_nx = x;
    b_nx = b;
    if (shift_ev) begin
      y_nx = y >> 1;
      x_nx = div_by_x(x, p);
    end else if (!unit_ev) begin
      y_nx = y_sum;
      x_nx = x_sum;
      if (swap_ev) begin
        d_nx = d ^ y_sum;
        b_nx = b ^ x_sum;
      end
    end
  end
endmodule

// File: rtl/gf2m_inverter.sv
module gf2m_inverter
  import gfinv_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = $clog2(W+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] m_in,
  input  logic [W-1:0]  a_in,
  input  logic [W:0]    p_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [W-1:0]  x_out
);
  localparam int PW = W + 1;
  localparam int DW = $clog2(PW);

  inv_state_t    state_q;
  logic [W:0]    y_q, d_q, p_q;
  logic [W-1:0]  x_q, b_q, res_q;
  logic [MW-1:0] m_q;
  logic          done_q, err_q;

  logic [W-1:0]  a_mask, a_m;
  logic [W:0]    p_mask, p_m;
  logic          a_zero;
  logic [DW-1:0] deg_y, deg_d;
  logic [W:0]    y_nx, d_nx;
  logic [W-1:0]  x_nx, b_nx;
  logic          shift_ev, unit_ev, swap_ev;

  always_comb begin
    for (int i = 0; i < W; i++)  a_mask[i] = (i <  int'(m_in));
    for (int i = 0; i < PW; i++) p_mask[i] = (i <= int'(m_in));
  end

  assign a_m    = a_in & a_mask;
  assign p_m    = p_in & p_mask;
  assign a_zero = (a_m == '0);

  gfinv_msb_enc #(.WIDTH(PW), .DW(DW)) u_deg_y (.vec(y_q), .deg(deg_y));
  gfinv_msb_enc #(.WIDTH(PW), .DW(DW)) u_deg_d (.vec(d_q), .deg(deg_d));

  gfinv_step #(.W(W), .DW(DW)) u_step (
    .y(y_q), .d(d_q), .x(x_q), .b(b_q), .p(p_q),
    .deg_y(deg_y), .deg_d(deg_d),
    .y_nx(y_nx), .d_nx(d_nx), .x_nx(x_nx), .b_nx(b_nx),
    .shift_ev(shift_ev), .unit_ev(unit_ev), .swap_ev(swap_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      y_q     <= '0;
      d_q     <= '0;
      p_q     <= '0;
      x_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      m_q     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            m_q <= m_in;
            if (a_zero) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              res_q  <= '0;
            end else begin
              y_q     <= {1'b0, a_m};
              d_q     <= p_m;
              p_q     <= p_m;
              x_q     <= W'(1);
              b_q     <= '0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (unit_ev) begin
            done_q  <= 1'b1;
            res_q   <= x_q;
            state_q <= ST_IDLE;
          end else begin
            y_q <= y_nx;
            d_q <= d_nx;
            x_q <= x_nx;
            b_q <= b_nx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state_q == ST_RUN);
  assign done  = done_q;
  assign err   = err_q;
  assign x_out = res_q;
endmodule

// File: rtl/gf2m_inverter_chk.sv
module gf2m_inverter_chk #(
  parameter int W  = 16,
  parameter int MW = $clog2(W+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          a_zero,
  input logic [MW-1:0] m_q,
  input logic [W-1:0]  x_out
);
  localparam int LIMIT = 4 * W + 4;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_cnt <= '0;
    else if (!busy) run_cnt <= '0;
    else            run_cnt <= run_cnt + 1'b1;
  end

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  err_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R3
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && a_zero) |=> (done && err && !busy && x_out == '0));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(m_q));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x_out) |-> done);

  // R2
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((x_out >> m_q) == '0));

  // R8
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_cnt) < LIMIT));
endmodule

bind gf2m_inverter gf2m_inverter_chk #(.W(W), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .a_zero(a_zero), .m_q(m_q), .x_out(x_out)
);

// File: tb/gf2m_inverter_tb.sv
module gf2m_inverter_tb;
  localparam int W     = 16;
  localparam int MW    = $clog2(W+1);
  localparam int LIMIT = 4 * W + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] m_in = '0;
  logic [W-1:0]  a_in = '0;
  logic [W:0]    p_in = '0;
  logic          busy, done, err;
  logic [W-1:0]  x_out;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gf2m_inverter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_in(m_in), .a_in(a_in),
    .p_in(p_in), .busy(busy), .done(done), .err(err), .x_out(x_out)
  );

  function automatic logic [16:0] poly_for(int m);
    case (m)
      4:  return 17'h00013;
      8:  return 17'h0011B;
      9:  return 17'h00211;
      10: return 17'h00409;
      11: return 17'h00805;
      12: return 17'h01053;
      13: return 17'h0201B;
      14: return 17'h04443;
      15: return 17'h08003;
      default: return 17'h1100B;
    endcase
  endfunction

  // carry-less product followed by long division by p, top bit downward
  function automatic logic [15:0] mulmod(logic [15:0] a, logic [15:0] b,
                                         logic [16:0] p, int m);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < 16; i++) if (b[i]) acc ^= (32'(a) << i);
    for (int k = 31; k >= m; k--) if (acc[k]) acc ^= (32'(p) << (k - m));
    return acc[15:0];
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic run_op(input int m, input logic [15:0] a, input logic [16:0] p,
                        output logic [15:0] x, output logic e, output int cyc);
    m_in  = MW'(m);
    a_in  = a;
    p_in  = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc <= LIMIT + 4) begin
      @(negedge clk);
      cyc++;
    end
    x = x_out;
    e = err;
  endtask

  task automatic check_inverse(input int m, input logic [15:0] a_eff,
                               input logic [16:0] p, input logic [15:0] x,
                               input logic e, input int cyc, input string req);
    logic [15:0] prod;
    prod = mulmod(x, a_eff, p, m);
    check(prod == 16'd1 && (32'(x) >> m) == 0 && !e, req, {15'd0, e, prod}, 32'd1);
    // R8
    check(cyc <= LIMIT, "R8 latency", cyc, LIMIT);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] x, x2, hold;
    logic        e;
    int          cyc;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && x_out == '0, "R1 reset",
          {busy, done, err, 13'd0, x_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 unit operand
    run_op(8, 16'h0001, poly_for(8), x, e, cyc);
    check(x == 16'h0001 && cyc == 1, "R7 unit", {cyc[15:0], x}, 32'h0001_0001);

    // R6 done lasts one cycle, not with busy
    run_op(8, 16'h0053, poly_for(8), x, e, cyc);
    check(x == 16'h00CA && !busy, "R2/R6 known inverse", x, 32'h00CA);
    @(negedge clk);
    check(!done && !busy, "R6 pulse", {busy, done}, 32'd0);

    // R9 result held while idle
    hold = x_out;
    repeat (5) @(negedge clk);
    check(x_out == hold, "R9 hold", x_out, hold);

    // R3 zero operand (upper garbage masked away), R10 err with zero only
    run_op(8, 16'hAB00, poly_for(8), x, e, cyc);
    check(e && x == 16'h0 && cyc == 0, "R3 zero", {cyc[7:0], 7'd0, e, x}, 32'h0001_0000);
    check(!busy, "R3 busy low", busy, 32'd0);
    @(negedge clk);
    check(!done && !err, "R10 err cleared", {done, err}, 32'd0);

    // R4 upper bits of a_in and p_in ignored
    run_op(8, 16'hF753, poly_for(8) | 17'h1_F000, x, e, cyc);
    check(x == 16'h00CA && !e, "R4 masked inputs", x, 32'h00CA);
    run_op(12, 16'h9123, poly_for(12) | 17'h1_E000, x, e, cyc);
    check_inverse(12, 16'h0123, poly_for(12), x, e, cyc, "R4 masked m=12");

    // R5 start while busy ignored
    m_in = MW'(13); a_in = 16'h1A2B; p_in = poly_for(13); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    a_in = 16'h0002; m_in = MW'(8); p_in = poly_for(8); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc <= LIMIT + 4) begin
      @(negedge clk);
      cyc++;
    end
    check_inverse(13, 16'h1A2B, poly_for(13), x_out, err, cyc, "R5 ignore start");

    // R2 exhaustive small field
    for (int a = 1; a < 16; a++) begin
      run_op(4, 16'(a), poly_for(4), x, e, cyc);
      check_inverse(4, 16'(a), poly_for(4), x, e, cyc, "R2 m=4 sweep");
    end

    // R2 top value of every field
    for (int m = 8; m <= 16; m++) begin
      logic [15:0] top;
      top = 16'((32'd1 << m) - 1);
      run_op(m, top, poly_for(m), x, e, cyc);
      check_inverse(m, top, poly_for(m), x, e, cyc, "R2 all-ones");
    end

    // R2 random operands, m in 8..16
    for (int n = 0; n < 400; n++) begin
      int          m;
      logic [15:0] a_raw, a_eff;
      m = 8 + int'($urandom % 9);
      a_raw = 16'($urandom);
      a_eff = 16'(32'(a_raw) & ((32'd1 << m) - 1));
      if (a_eff == 0) a_eff = 16'd1;
      run_op(m, a_eff, poly_for(m), x, e, cyc);
      check_inverse(m, a_eff, poly_for(m), x, e, cyc, "R2 random");
    end

    // R9 successive results replace each other
    run_op(16, 16'h8001, poly_for(16), x, e, cyc);
    run_op(16, 16'h4000, poly_for(16), x2, e, cyc);
    check_inverse(16, 16'h4000, poly_for(16), x2, e, cyc, "R9 new result");

    finish_run();
  end
endmodule